// File: doc/BRIEF.md
# Isochronous Receive Context Matcher

The block decides which receive context gets each incoming isochronous packet. There are eight contexts. Each one holds an enable, a channel number and a multi-channel mode bit, and software sets them by writing one 32-bit control word per context. A shared 64-bit mask lists the channels that the multi-channel context accepts.

Only one context at a time may own multi-channel mode. While a context owns it, that context matches on the mask and ignores its own channel field. When a packet header strobe arrives with its 6-bit channel number, the block answers one cycle later with a one-hot context select, or with a one-cycle no-match flag when no enabled context takes the channel. A new strobe may arrive every cycle, so every context can receive in every isochronous cycle.

Top module: `irm_ctx_matcher`

## Requirements
- R1: After reset, `sel_o` is all zero, `miss_o` is low, every context is disabled and no context owns multi-channel mode, so any packet produces a miss.
- R2: A write with `cfg_we_i` high stores `cfg_word_i` into context `cfg_ctx_i`. In that word, bit 31 is the enable, bit 28 requests multi-channel mode and bits 5:0 are the channel. The new value applies to packets strobed from the next cycle on.
- R3: For a strobe whose channel equals the channel of an enabled single-channel context, `sel_o` has exactly that context's bit set in the cycle after the strobe.
- R4: When several enabled single-channel contexts hold the same channel, the lowest-numbered one is selected.
- R5: The enabled multi-channel owner is selected for any channel whose bit is set in the mask (bit n stands for channel n). `mask_we_i` loads the whole mask from `mask_i`.
- R6: A single-channel match wins over the multi-channel owner, even when the mask also holds that channel.
- R7: A multi-channel request written to a context while a different context owns the mode is rejected. The first owner keeps the mode, and the requesting context works as a single-channel context on its channel field.
- R8: Writing a word with bit 28 clear to the owner releases the mode. The released context then matches on its channel field, and a later request from any context can take the mode.
- R9: `miss_o` is high for exactly the one cycle after a strobe that no enabled context accepts. In a cycle after no strobe, both `sel_o` and `miss_o` are zero.
- R10: A disabled context never matches, on its own channel or, when it is the owner, through the mask.
- R11: Strobes in consecutive cycles each get their own answer in the cycle that follows each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Context control word write strobe |
| cfg_ctx_i | input | 3 | Index of the context to write |
| cfg_word_i | input | 32 | Control word: bit 31 enable, bit 28 multi-channel, bits 5:0 channel |
| mask_we_i | input | 1 | Multi-channel mask write strobe |
| mask_i | input | 64 | Multi-channel mask, bit n enables channel n |
| pkt_valid_i | input | 1 | Packet header strobe |
| pkt_chan_i | input | 6 | Channel number of the strobed packet |
| sel_o | output | 8 | One-hot selected context, valid for one cycle |
| miss_o | output | 1 | No-match pulse |

## Verification
The select and the no-match flag both come from a single register stage, so each answer is due in the first cycle after its strobe. Configuration and mask writes take effect for strobes in the following cycle. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which is half a cycle after the register has captured its answer. For back-to-back strobes it checks each answer on the falling edge that follows its own strobe, and it checks an idle falling edge after the last strobe to confirm that the outputs return to zero.

// File: rtl/irm_pkg.sv
package irm_pkg;
  localparam int unsigned NUM_CTX_D = 8;
  localparam int unsigned CHAN_W_D  = 6;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned MC_BIT    = 28;
endpackage

// File: rtl/irm_cfg.sv
module irm_cfg
  import irm_pkg::*;
#(
  parameter int unsigned NUM_CTX  = NUM_CTX_D,
  parameter int unsigned CHAN_W   = CHAN_W_D,
  localparam int unsigned CTX_W   = $clog2(NUM_CTX),
  localparam int unsigned NUM_CHAN = 1 << CHAN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CTX_W-1:0]    cfg_ctx_i,
  input  logic [WORD_W-1:0]   cfg_word_i,
  input  logic                mask_we_i,
  input  logic [NUM_CHAN-1:0] mask_i,
  output logic [NUM_CTX-1:0]  ctx_en_o,
  output logic [CHAN_W-1:0]   ctx_chan_o [NUM_CTX],
  output logic                mc_valid_o,
  output logic [CTX_W-1:0]    mc_owner_o,
  output logic [NUM_CHAN-1:0] mask_o
);
  logic wr_mc, grant, release_mc;
  logic unused_word;

  assign unused_word = ^{cfg_word_i[EN_BIT-1:MC_BIT+1], cfg_word_i[MC_BIT-1:CHAN_W]};
  assign wr_mc      = cfg_word_i[MC_BIT];
  assign grant      = cfg_we_i && wr_mc && (!mc_valid_o || mc_owner_o == cfg_ctx_i);
  assign release_mc = cfg_we_i && !wr_mc && mc_valid_o && mc_owner_o == cfg_ctx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_en_o   <= '0;
      ctx_chan_o <= '{default: '0};
      mc_valid_o <= 1'b0;
      mc_owner_o <= '0;
      mask_o     <= '0;
    end else begin
      if (cfg_we_i) begin
        ctx_en_o[cfg_ctx_i]   <= cfg_word_i[EN_BIT];
        ctx_chan_o[cfg_ctx_i] <= cfg_word_i[CHAN_W-1:0];
      end
      if (grant) begin
        mc_valid_o <= 1'b1;
        mc_owner_o <= cfg_ctx_i;
      end else if (release_mc) begin
        mc_valid_o <= 1'b0;
      end
      if (mask_we_i) mask_o <= mask_i;
    end
  end

  // a competing request must leave ownership untouched
  assert_owner_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_valid_o && cfg_we_i && cfg_ctx_i != mc_owner_o)
      |=> (mc_valid_o && mc_owner_o == $past(mc_owner_o)));

  assert_owner_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_valid_o && cfg_we_i && cfg_ctx_i == mc_owner_o && !cfg_word_i[MC_BIT])
      |=> !mc_valid_o);
endmodule

// File: rtl/irm_match.sv
module irm_match
  import irm_pkg::*;
#(
  parameter int unsigned NUM_CTX  = NUM_CTX_D,
  parameter int unsigned CHAN_W   = CHAN_W_D,
  localparam int unsigned CTX_W   = $clog2(NUM_CTX),
  localparam int unsigned NUM_CHAN = 1 << CHAN_W
) (
  input  logic [CHAN_W-1:0]   pkt_chan_i,
  input  logic [NUM_CTX-1:0]  ctx_en_i,
  input  logic [CHAN_W-1:0]   ctx_chan_i [NUM_CTX],
  input  logic                mc_valid_i,
  input  logic [CTX_W-1:0]    mc_owner_i,
  input  logic [NUM_CHAN-1:0] mask_i,
  output logic [NUM_CTX-1:0]  single_hit_o,
  output logic                mc_hit_o
);
  for (genvar k = 0; k < NUM_CTX; k++) begin : g_ctx
    logic is_owner;
    assign is_owner        = mc_valid_i && mc_owner_i == CTX_W'(k);
    assign single_hit_o[k] = ctx_en_i[k] && !is_owner && ctx_chan_i[k] == pkt_chan_i;
  end

  assign mc_hit_o = mc_valid_i && ctx_en_i[mc_owner_i] && mask_i[pkt_chan_i];
endmodule

// File: rtl/irm_arb.sv
module irm_arb
  import irm_pkg::*;
#(
  parameter int unsigned NUM_CTX = NUM_CTX_D,
  localparam int unsigned CTX_W  = $clog2(NUM_CTX)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pkt_valid_i,
  input  logic [NUM_CTX-1:0] single_hit_i,
  input  logic               mc_hit_i,
  input  logic [CTX_W-1:0]   mc_owner_i,
  output logic [NUM_CTX-1:0] sel_o,
  output logic               miss_o
);
  logic [NUM_CTX-1:0] nxt_sel;
  logic               found;

  always_comb begin
    nxt_sel = '0;
    found   = 1'b0;
    for (int k = 0; k < NUM_CTX; k++) begin
      if (single_hit_i[k] && !found) begin
        nxt_sel[k] = 1'b1;
        found      = 1'b1;
      end
    end
    if (!found && mc_hit_i) nxt_sel[mc_owner_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= '0;
      miss_o <= 1'b0;
    end else begin
      sel_o  <= pkt_valid_i ? nxt_sel : '0;
      miss_o <= pkt_valid_i && nxt_sel == '0;
    end
  end

  assert_sel_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  assert_single_hit_no_miss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && single_hit_i != '0) |=> (!miss_o && sel_o != '0));

  assert_mask_only_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && single_hit_i == '0 && mc_hit_i) |=> sel_o[$past(mc_owner_i)]);

  assert_miss_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(miss_o && sel_o != '0));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> (sel_o == '0 && !miss_o));

  assert_every_strobe_answered_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> (miss_o || sel_o != '0));
endmodule

// File: rtl/irm_ctx_matcher.sv
module irm_ctx_matcher
  import irm_pkg::*;
#(
  parameter int unsigned NUM_CTX  = NUM_CTX_D,
  parameter int unsigned CHAN_W   = CHAN_W_D,
  localparam int unsigned CTX_W   = $clog2(NUM_CTX),
  localparam int unsigned NUM_CHAN = 1 << CHAN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [CTX_W-1:0]    cfg_ctx_i,
  input  logic [WORD_W-1:0]   cfg_word_i,
  input  logic                mask_we_i,
  input  logic [NUM_CHAN-1:0] mask_i,
  input  logic                pkt_valid_i,
  input  logic [CHAN_W-1:0]   pkt_chan_i,
  output logic [NUM_CTX-1:0]  sel_o,
  output logic                miss_o
);
  logic [NUM_CTX-1:0]  ctx_en;
  logic [CHAN_W-1:0]   ctx_chan [NUM_CTX];
  logic                mc_valid;
  logic [CTX_W-1:0]    mc_owner;
  logic [NUM_CHAN-1:0] mask_q;
  logic [NUM_CTX-1:0]  single_hit;
  logic                mc_hit;

  irm_cfg #(.NUM_CTX(NUM_CTX), .CHAN_W(CHAN_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_ctx_i  (cfg_ctx_i),
    .cfg_word_i (cfg_word_i),
    .mask_we_i  (mask_we_i),
    .mask_i     (mask_i),
    .ctx_en_o   (ctx_en),
    .ctx_chan_o (ctx_chan),
    .mc_valid_o (mc_valid),
    .mc_owner_o (mc_owner),
    .mask_o     (mask_q)
  );

  irm_match #(.NUM_CTX(NUM_CTX), .CHAN_W(CHAN_W)) u_match (
    .pkt_chan_i   (pkt_chan_i),
    .ctx_en_i     (ctx_en),
    .ctx_chan_i   (ctx_chan),
    .mc_valid_i   (mc_valid),
    .mc_owner_i   (mc_owner),
    .mask_i       (mask_q),
    .single_hit_o (single_hit),
    .mc_hit_o     (mc_hit)
  );

  irm_arb #(.NUM_CTX(NUM_CTX)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pkt_valid_i  (pkt_valid_i),
    .single_hit_i (single_hit),
    .mc_hit_i     (mc_hit),
    .mc_owner_i   (mc_owner),
    .sel_o        (sel_o),
    .miss_o       (miss_o)
  );
endmodule

// File: tb/irm_ctx_matcher_tb.sv
module irm_ctx_matcher_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_ctx_i = '0;
  logic [31:0] cfg_word_i = '0;
  logic        mask_we_i = 1'b0;
  logic [63:0] mask_i = '0;
  logic        pkt_valid_i = 1'b0;
  logic [5:0]  pkt_chan_i = '0;
  logic [7:0]  sel_o;
  logic        miss_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  irm_ctx_matcher u_dut (.*);

  // {channel, expected select, expected miss}
  localparam int NV = 7;
  localparam logic [14:0] VEC [NV] = '{
    {6'd3,  8'b0000_0001, 1'b0},  // R4 lowest of ctx0/ctx1, R6 beats mask bit 3
    {6'd40, 8'b0001_0000, 1'b0},  // R6 ctx4 beats mask bit 40
    {6'd12, 8'b0000_0100, 1'b0},  // R5 mask hit to owner ctx2
    {6'd50, 8'b0000_0100, 1'b0},  // R5
    {6'd7,  8'b0000_0000, 1'b1},  // R10 ctx6 disabled
    {6'd0,  8'b0000_0000, 1'b1},  // R9
    {6'd63, 8'b0000_0000, 1'b1}   // R9
  };

  task automatic check(input string req, input logic [7:0] exp_sel, input logic exp_miss);
    n_chk++;
    if (sel_o !== exp_sel || miss_o !== exp_miss) begin
      n_err++;
      $display("FAIL %s: sel=%b miss=%b expected sel=%b miss=%b",
               req, sel_o, miss_o, exp_sel, exp_miss);
    end
  endtask

  task automatic wr_ctx(input int k, input logic en, input logic mc, input logic [5:0] ch);
    @(negedge clk_i);
    cfg_we_i   = 1'b1;
    cfg_ctx_i  = 3'(k);
    cfg_word_i = '0;
    cfg_word_i[31] = en;
    cfg_word_i[28] = mc;
    cfg_word_i[5:0] = ch;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic wr_mask(input logic [63:0] m);
    @(negedge clk_i);
    mask_we_i = 1'b1;
    mask_i    = m;
    @(negedge clk_i);
    mask_we_i = 1'b0;
  endtask

  // strobe on one falling edge, sample on the next (one register stage)
  task automatic send(input logic [5:0] ch, input string req,
                      input logic [7:0] exp_sel, input logic exp_miss);
    @(negedge clk_i);
    pkt_valid_i = 1'b1;
    pkt_chan_i  = ch;
    @(negedge clk_i);
    pkt_valid_i = 1'b0;
    check(req, exp_sel, exp_miss);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 outputs in reset", 8'h00, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 outputs after reset", 8'h00, 1'b0);
    send(6'd0, "R1 no context enabled", 8'h00, 1'b1);

    wr_ctx(0, 1'b1, 1'b0, 6'd3);
    wr_ctx(1, 1'b1, 1'b0, 6'd3);
    wr_ctx(2, 1'b1, 1'b1, 6'd12);
    wr_ctx(4, 1'b1, 1'b0, 6'd40);
    wr_ctx(6, 1'b0, 1'b0, 6'd7);
    wr_mask((64'd1 << 3) | (64'd1 << 12) | (64'd1 << 40) | (64'd1 << 50));
    send(6'd40, "R2 R3 single ctx4", 8'b0001_0000, 1'b0);

    for (int i = 0; i < NV; i++)
      send(VEC[i][14:9], "R3 R4 R5 R6 R10 table", VEC[i][8:1], VEC[i][0]);

    @(negedge clk_i);
    check("R9 idle quiet", 8'h00, 1'b0);

    // rejected second request
    wr_ctx(5, 1'b1, 1'b1, 6'd20);
    send(6'd20, "R7 rejected ctx acts single", 8'b0010_0000, 1'b0);
    send(6'd12, "R7 first owner kept", 8'b0000_0100, 1'b0);

    // release and re-acquire
    wr_ctx(2, 1'b1, 1'b0, 6'd9);
    send(6'd12, "R8 released mask no hit", 8'h00, 1'b1);
    send(6'd9, "R8 released ctx single", 8'b0000_0100, 1'b0);
    wr_ctx(5, 1'b1, 1'b1, 6'd20);
    send(6'd50, "R8 new owner ctx5", 8'b0010_0000, 1'b0);
    send(6'd20, "R8 owner ignores own channel", 8'h00, 1'b1);

    wr_ctx(5, 1'b0, 1'b1, 6'd20);
    send(6'd50, "R10 disabled owner", 8'h00, 1'b1);

    // back-to-back strobes
    @(negedge clk_i);
    pkt_valid_i = 1'b1;
    pkt_chan_i  = 6'd3;
    @(negedge clk_i);
    check("R11 first strobe", 8'b0000_0001, 1'b0);
    pkt_chan_i = 6'd40;
    @(negedge clk_i);
    check("R11 second strobe", 8'b0001_0000, 1'b0);
    pkt_chan_i = 6'd33;
    @(negedge clk_i);
    pkt_valid_i = 1'b0;
    check("R11 third strobe miss", 8'h00, 1'b1);
    @(negedge clk_i);
    check("R9 quiet after burst", 8'h00, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule